// File: doc/BRIEF.md
# Timer Flag Register with Access-Triggered Clearing

This block keeps the status flags of an eight-channel timer and decides when each flag is cleared. There are three groups of flags: one flag for each channel, raised on a capture or compare event; a counter overflow flag; and two pulse-accumulator flags, one for overflow and one for input edges. The channel, counter and accumulator logic raise these flags with single-cycle set pulses. Software reads the flags over a simple byte-wide register bus made of an address, a read strobe, a write strobe, write data and combinational read data.

In the default mode, software clears a flag by writing a one to its bit. A mode bit in a control byte turns on a second clearing path. While it is set, a normal access to the data register tied to a flag also clears that flag, so an interrupt handler needs no separate clear step. For each channel the external channel-mode vector decides which access counts. Reading a capture channel's register clears that channel's flag. Writing a compare channel's register clears it.

Top module: `tflg_top`

## Requirements
- R1: After a synchronous reset every flag is 0 and the fast-clear mode bit is 0. The mode bit reads back at address 0x06, bit 4, and a write to 0x06 loads it from write-data bit 4.
- R2: A set pulse raises its flag at the next clock edge. Reads return the flags as follows: address 0x0E bit n is channel n; address 0x0F bit 7 is counter overflow; address 0x21 bit 1 is accumulator overflow and bit 0 is accumulator edge. All other bits and addresses read 0.
- R3: In either mode, writing a 1 to a flag bit at 0x0E, 0x0F or 0x21 clears that flag. Writing a 0 leaves it unchanged.
- R4: With the mode bit at 0, reads and writes of the counter, channel and accumulator data addresses leave every flag unchanged.
- R5: With the mode bit at 1, a read of address 0x10+2n or 0x11+2n clears channel n's flag when ch_cmp_mode[n] is 0 (capture). A write to those addresses leaves a capture channel's flag alone.
- R6: With the mode bit at 1, a write to address 0x10+2n or 0x11+2n clears channel n's flag when ch_cmp_mode[n] is 1 (compare). A read leaves a compare channel's flag alone.
- R7: With the mode bit at 1, any read or write of address 0x04 or 0x05 clears the counter overflow flag.
- R8: With the mode bit at 1, any read or write of address 0x22 or 0x23 clears both accumulator flags.
- R9: When a set pulse and a clear event reach the same flag in the same cycle, the flag ends up 1.
- R10: A clear caused by an access affects only the flags that belong to the address accessed. All other flags keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Register byte address |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| ch_set | input | 8 | Per-channel flag set pulses |
| cnt_ovf_set | input | 1 | Counter overflow set pulse |
| acc_ovf_set | input | 1 | Accumulator overflow set pulse |
| acc_edge_set | input | 1 | Accumulator input-edge set pulse |
| ch_cmp_mode | input | 8 | Channel mode, 1 = compare, 0 = capture |
| ch_flag | output | 8 | Channel flags |
| cnt_ovf_flag | output | 1 | Counter overflow flag |
| acc_ovf_flag | output | 1 | Accumulator overflow flag |
| acc_edge_flag | output | 1 | Accumulator input-edge flag |

## Verification
Directed sequences cover each clearing path in both modes. Every channel access is repeated with reads and with writes against both capture and compare channels, which separates a decode that ignores direction from one that ignores channel mode. The same data-register accesses are also made with the mode bit cleared, so a fast-clear path that is always on gets caught. Accesses are made to both bytes of each register pair, and set pulses are driven in the same cycle as clears, so that byte decoding and set priority are both exercised. Random address, strobe, set and mode traffic then runs against a reference model in the bench to find interactions the directed cases miss.

// File: rtl/tflg_pkg.sv
package tflg_pkg;
    localparam int NCH = 8;
    localparam int AW  = 8;
    localparam int DW  = 8;

    localparam logic [AW-1:0] A_CNT   = 8'h04;
    localparam logic [AW-1:0] A_CTRL  = 8'h06;
    localparam logic [AW-1:0] A_CHFLG = 8'h0E;
    localparam logic [AW-1:0] A_OVFLG = 8'h0F;
    localparam logic [AW-1:0] A_CHAN  = 8'h10;
    localparam logic [AW-1:0] A_PAFLG = 8'h21;
    localparam logic [AW-1:0] A_PACNT = 8'h22;

    localparam int FAST_BIT   = 4;
    localparam int OVF_BIT    = 7;
    localparam int PAOVF_BIT  = 1;
    localparam int PAEDGE_BIT = 0;

    typedef struct packed {
        logic [NCH-1:0] ch;
        logic           cnt_ovf;
        logic           acc_ovf;
        logic           acc_edge;
    } flags_t;

    localparam int FLAGS_W = $bits(flags_t);

    // true when addr hits either byte of the even-aligned pair starting at lo
    function automatic logic in_pair(input logic [AW-1:0] addr, input logic [AW-1:0] lo);
        return addr[AW-1:1] == lo[AW-1:1];
    endfunction
endpackage

// File: rtl/tflg_mode_reg.sv
module tflg_mode_reg
    import tflg_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] addr,
    input  logic          wr,
    input  logic          wbit,
    output logic          fast
);
    always_ff @(posedge clk) begin
        if (rst)
            fast <= 1'b0;
        else if (wr && addr == A_CTRL)
            fast <= wbit;
    end

    assert_mode_reset_R1: assert property (@(posedge clk) rst |=> !fast);
endmodule

// File: rtl/tflg_clear_decode.sv
module tflg_clear_decode
    import tflg_pkg::*;
(
    input  logic [AW-1:0]  addr,
    input  logic           rd,
    input  logic           wr,
    input  logic [DW-1:0]  wdata,
    input  logic           fast,
    input  logic [NCH-1:0] cmp_mode,
    output flags_t         clr
);
    logic           access;
    logic [NCH-1:0] side_ch;
    logic [NCH-1:0] w1c_ch;

    assign access = rd | wr;
    assign w1c_ch = (wr && addr == A_CHFLG) ? wdata[NCH-1:0] : '0;

    for (genvar n = 0; n < NCH; n++) begin : g_chan
        localparam logic [AW-1:0] LO = A_CHAN + AW'(2 * n);
        assign side_ch[n] = fast && in_pair(addr, LO) && (cmp_mode[n] ? wr : rd);
    end

    always_comb begin
        clr.ch       = w1c_ch | side_ch;
        clr.cnt_ovf  = (wr && addr == A_OVFLG && wdata[OVF_BIT])
                     || (fast && access && in_pair(addr, A_CNT));
        clr.acc_ovf  = (wr && addr == A_PAFLG && wdata[PAOVF_BIT])
                     || (fast && access && in_pair(addr, A_PACNT));
        clr.acc_edge = (wr && addr == A_PAFLG && wdata[PAEDGE_BIT])
                     || (fast && access && in_pair(addr, A_PACNT));
    end
endmodule

// File: rtl/tflg_flag_bank.sv
module tflg_flag_bank #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] set,
    input  logic [W-1:0] clr,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else
            q <= (q & ~clr) | set;
    end

    assert_bank_reset_R1: assert property (@(posedge clk) rst |=> q == '0);

    assert_set_wins_R9: assert property (@(posedge clk) disable iff (rst)
        (set != '0) |=> ((q & $past(set)) == $past(set)));

    assert_clear_drops_R3: assert property (@(posedge clk) disable iff (rst)
        ((clr & ~set) != '0) |=> ((q & $past(clr & ~set)) == '0));
endmodule

// File: rtl/tflg_top.sv
module tflg_top
    import tflg_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic [AW-1:0]  bus_addr,
    input  logic           bus_rd,
    input  logic           bus_wr,
    input  logic [DW-1:0]  bus_wdata,
    output logic [DW-1:0]  bus_rdata,
    input  logic [NCH-1:0] ch_set,
    input  logic           cnt_ovf_set,
    input  logic           acc_ovf_set,
    input  logic           acc_edge_set,
    input  logic [NCH-1:0] ch_cmp_mode,
    output logic [NCH-1:0] ch_flag,
    output logic           cnt_ovf_flag,
    output logic           acc_ovf_flag,
    output logic           acc_edge_flag
);
    logic   fast;
    flags_t set_v;
    flags_t clr_v;
    flags_t q_v;

    assign set_v = '{ch: ch_set, cnt_ovf: cnt_ovf_set, acc_ovf: acc_ovf_set, acc_edge: acc_edge_set};

    tflg_mode_reg u_mode (
        .clk  (clk),
        .rst  (rst),
        .addr (bus_addr),
        .wr   (bus_wr),
        .wbit (bus_wdata[FAST_BIT]),
        .fast (fast)
    );

    tflg_clear_decode u_dec (
        .addr     (bus_addr),
        .rd       (bus_rd),
        .wr       (bus_wr),
        .wdata    (bus_wdata),
        .fast     (fast),
        .cmp_mode (ch_cmp_mode),
        .clr      (clr_v)
    );

    tflg_flag_bank #(.W(FLAGS_W)) u_bank (
        .clk (clk),
        .rst (rst),
        .set (set_v),
        .clr (clr_v),
        .q   (q_v)
    );

    assign ch_flag       = q_v.ch;
    assign cnt_ovf_flag  = q_v.cnt_ovf;
    assign acc_ovf_flag  = q_v.acc_ovf;
    assign acc_edge_flag = q_v.acc_edge;

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_CTRL:  bus_rdata[FAST_BIT]   = fast;
            A_CHFLG: bus_rdata[NCH-1:0]    = q_v.ch;
            A_OVFLG: bus_rdata[OVF_BIT]    = q_v.cnt_ovf;
            A_PAFLG: begin
                bus_rdata[PAOVF_BIT]  = q_v.acc_ovf;
                bus_rdata[PAEDGE_BIT] = q_v.acc_edge;
            end
            default: bus_rdata = '0;
        endcase
    end

    logic not_flag_addr;
    assign not_flag_addr = bus_addr != A_CHFLG && bus_addr != A_OVFLG && bus_addr != A_PAFLG;

    assert_normal_no_side_R4: assert property (@(posedge clk) disable iff (rst)
        (!fast && (bus_rd || bus_wr) && not_flag_addr && set_v == '0) |=> (q_v == $past(q_v)));

    assert_cnt_fast_clear_R7: assert property (@(posedge clk) disable iff (rst)
        (fast && (bus_rd || bus_wr) && in_pair(bus_addr, A_CNT) && !cnt_ovf_set) |=> !cnt_ovf_flag);

    assert_acc_fast_clear_R8: assert property (@(posedge clk) disable iff (rst)
        (fast && (bus_rd || bus_wr) && in_pair(bus_addr, A_PACNT) && !acc_ovf_set && !acc_edge_set)
        |=> (!acc_ovf_flag && !acc_edge_flag));

    for (genvar n = 0; n < NCH; n++) begin : g_chk
        localparam logic [AW-1:0] LO = A_CHAN + AW'(2 * n);
        assert_capture_read_R5: assert property (@(posedge clk) disable iff (rst)
            (fast && bus_rd && in_pair(bus_addr, LO) && !ch_cmp_mode[n] && !ch_set[n]) |=> !ch_flag[n]);
        assert_compare_write_R6: assert property (@(posedge clk) disable iff (rst)
            (fast && bus_wr && in_pair(bus_addr, LO) && ch_cmp_mode[n] && !ch_set[n]) |=> !ch_flag[n]);
    end
endmodule

// File: tb/sim_tflg_top.sv
module sim_tflg_top;
    import tflg_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] bus_addr = '0;
    logic       bus_rd = 1'b0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [7:0] ch_set = '0;
    logic       cnt_ovf_set = 1'b0;
    logic       acc_ovf_set = 1'b0;
    logic       acc_edge_set = 1'b0;
    logic [7:0] ch_cmp_mode = '0;
    logic [7:0] ch_flag;
    logic       cnt_ovf_flag, acc_ovf_flag, acc_edge_flag;

    always #(CLK_PERIOD/2) clk = ~clk;

    tflg_top u0 (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ch_set(ch_set),
        .cnt_ovf_set(cnt_ovf_set), .acc_ovf_set(acc_ovf_set), .acc_edge_set(acc_edge_set),
        .ch_cmp_mode(ch_cmp_mode), .ch_flag(ch_flag), .cnt_ovf_flag(cnt_ovf_flag),
        .acc_ovf_flag(acc_ovf_flag), .acc_edge_flag(acc_edge_flag)
    );

    int checks = 0;
    int errors = 0;

    logic [7:0] m_ch = '0;
    logic m_ovf = 1'b0, m_pao = 1'b0, m_pae = 1'b0, m_fast = 1'b0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic pair(input logic [7:0] a, input logic [7:0] lo);
        return a[7:1] == lo[7:1];
    endfunction

    function automatic logic [7:0] mread(input logic [7:0] a);
        case (a)
            8'h06:   return {3'b000, m_fast, 4'b0000};
            8'h0E:   return m_ch;
            8'h0F:   return {m_ovf, 7'b0};
            8'h21:   return {6'b0, m_pao, m_pae};
            default: return 8'h00;
        endcase
    endfunction

    task automatic model_step();
        logic [7:0] cc;
        logic co, cp, ce, acc;
        acc = bus_rd | bus_wr;
        cc  = (bus_wr && bus_addr == 8'h0E) ? bus_wdata : 8'h00;
        for (int n = 0; n < 8; n++)
            if (m_fast && pair(bus_addr, 8'h10 + 8'(2*n)) && (ch_cmp_mode[n] ? bus_wr : bus_rd))
                cc[n] = 1'b1;
        co = (bus_wr && bus_addr == 8'h0F && bus_wdata[7]) || (m_fast && acc && pair(bus_addr, 8'h04));
        cp = (bus_wr && bus_addr == 8'h21 && bus_wdata[1]) || (m_fast && acc && pair(bus_addr, 8'h22));
        ce = (bus_wr && bus_addr == 8'h21 && bus_wdata[0]) || (m_fast && acc && pair(bus_addr, 8'h22));
        m_ch  = (m_ch & ~cc) | ch_set;
        m_ovf = (m_ovf & ~co) | cnt_ovf_set;
        m_pao = (m_pao & ~cp) | acc_ovf_set;
        m_pae = (m_pae & ~ce) | acc_edge_set;
        if (bus_wr && bus_addr == 8'h06) m_fast = bus_wdata[4];
    endtask

    task automatic cyc(input logic [7:0] a, input logic r, input logic w, input logic [7:0] d,
                       input logic [7:0] cs, input logic os, input logic ps, input logic es,
                       input logic [7:0] cmp, input string req);
        @(negedge clk);
        bus_addr = a; bus_rd = r; bus_wr = w; bus_wdata = d;
        ch_set = cs; cnt_ovf_set = os; acc_ovf_set = ps; acc_edge_set = es; ch_cmp_mode = cmp;
        #1;
        if (r) chk({req, " rdata"}, 32'(bus_rdata), 32'(mread(a)));
        @(posedge clk);
        model_step();
        #1;
        chk({req, " flags"}, 32'({ch_flag, cnt_ovf_flag, acc_ovf_flag, acc_edge_flag}),
            32'({m_ch, m_ovf, m_pao, m_pae}));
    endtask

    task automatic idle(input string req);
        cyc(8'h00, 1'b0, 1'b0, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0, ch_cmp_mode, req);
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        checks++; errors++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        cyc(8'h06, 1, 0, 8'h00, 8'h00, 0, 0, 0, 8'hF0, "R1 reset mode bit");
        cyc(8'h0E, 1, 0, 8'h00, 8'h00, 0, 0, 0, 8'hF0, "R1 reset flags");
        // R2 set pulses and readback layout
        cyc(8'h00, 0, 0, 8'h00, 8'hA5, 1, 1, 1, 8'hF0, "R2 set pulses");
        cyc(8'h0E, 1, 0, 8'h00, 8'h00, 0, 0, 0, 8'hF0, "R2 read channel flags");
        cyc(8'h0F, 1, 0, 8'h00, 8'h00, 0, 0, 0, 8'hF0, "R2 read overflow flag");
        cyc(8'h21, 1, 0, 8'h00, 8'h00, 0, 0, 0, 8'hF0, "R2 read accumulator flags");
        cyc(8'h30, 1, 0, 8'h00, 8'h00, 0, 0, 0, 8'hF0, "R2 unmapped reads zero");
        // R3 write-one-to-clear, normal mode
        cyc(8'h0E, 0, 1, 8'h05, 8'h00, 0, 0, 0, 8'hF0, "R3 clear ch0 ch2");
        chk("R3 ch flags after w1c", 32'(ch_flag), 32'h000000A0);
        cyc(8'h0F, 0, 1, 8'h7F, 8'h00, 0, 0, 0, 8'hF0, "R3 zero in bit7 keeps overflow");
        chk("R3 overflow kept", 32'(cnt_ovf_flag), 32'd1);
        cyc(8'h21, 0, 1, 8'h01, 8'h00, 0, 0, 0, 8'hF0, "R3 clear edge only");
        // R4 normal-mode data accesses have no effect
        cyc(8'h00, 0, 0, 8'h00, 8'hFF, 1, 1, 1, 8'hF0, "R4 refill");
        cyc(8'h10, 1, 0, 8'h00, 8'h00, 0, 0, 0, 8'hF0, "R4 read capture reg");
        cyc(8'h1E, 0, 1, 8'h00, 8'h00, 0, 0, 0, 8'hF0, "R4 write compare reg");
        cyc(8'h05, 1, 0, 8'h00, 8'h00, 0, 0, 0, 8'hF0, "R4 read counter");
        cyc(8'h22, 0, 1, 8'h00, 8'h00, 0, 0, 0, 8'hF0, "R4 write accumulator");
        chk("R4 all flags held", 32'({ch_flag, cnt_ovf_flag, acc_ovf_flag, acc_edge_flag}), 32'h7FF);
        // enable fast clear
        cyc(8'h06, 0, 1, 8'h10, 8'h00, 0, 0, 0, 8'hF0, "R1 write mode bit");
        cyc(8'h06, 1, 0, 8'h00, 8'h00, 0, 0, 0, 8'hF0, "R1 mode bit readback");
        // R5 capture channels clear on read
        cyc(8'h11, 1, 0, 8'h00, 8'h00, 0, 0, 0, 8'hF0, "R5 read ch0 high byte");
        chk("R10 only ch0 cleared", 32'(ch_flag), 32'h000000FE);
        cyc(8'h12, 0, 1, 8'h00, 8'h00, 0, 0, 0, 8'hF0, "R5 write to capture ch1 ignored");
        chk("R5 ch1 still set", 32'(ch_flag[1]), 32'd1);
        cyc(8'h16, 1, 0, 8'h00, 8'h00, 0, 0, 0, 8'hF0, "R5 read ch3 low byte");
        // R6 compare channels clear on write
        cyc(8'h1C, 1, 0, 8'h00, 8'h00, 0, 0, 0, 8'hF0, "R6 read of compare ch6 ignored");
        chk("R6 ch6 still set", 32'(ch_flag[6]), 32'd1);
        cyc(8'h1F, 0, 1, 8'h00, 8'h00, 0, 0, 0, 8'hF0, "R6 write ch7");
        chk("R10 after ch7 write", 32'(ch_flag), 32'h00000076);
        // R7 counter overflow
        cyc(8'h05, 1, 0, 8'h00, 8'h00, 0, 0, 0, 8'hF0, "R7 read counter high");
        chk("R7 overflow cleared", 32'(cnt_ovf_flag), 32'd0);
        cyc(8'h00, 0, 0, 8'h00, 8'h00, 1, 0, 0, 8'hF0, "R7 set again");
        cyc(8'h04, 0, 1, 8'h00, 8'h00, 0, 0, 0, 8'hF0, "R7 write counter low");
        // R8 accumulator flags
        cyc(8'h23, 1, 0, 8'h00, 8'h00, 0, 0, 0, 8'hF0, "R8 read accumulator low");
        chk("R8 both cleared", 32'({acc_ovf_flag, acc_edge_flag}), 32'd0);
        cyc(8'h00, 0, 0, 8'h00, 8'h00, 0, 1, 1, 8'hF0, "R8 set again");
        cyc(8'h22, 0, 1, 8'h00, 8'h00, 0, 0, 0, 8'hF0, "R8 write accumulator high");
        // R9 set beats clear
        cyc(8'h1A, 1, 0, 8'h00, 8'h01 << 5, 0, 0, 0, 8'h00, "R9 set and read clear ch5");
        chk("R9 ch5 set wins", 32'(ch_flag[5]), 32'd1);
        cyc(8'h0E, 0, 1, 8'hFF, 8'h04, 0, 0, 0, 8'h00, "R9 set and w1c ch2");
        chk("R9 ch2 set wins", 32'(ch_flag), 32'h00000004);
        cyc(8'h04, 1, 0, 8'h00, 8'h00, 1, 0, 0, 8'h00, "R9 set and fast clear overflow");
        chk("R9 overflow set wins", 32'(cnt_ovf_flag), 32'd1);
        idle("R10 idle");
        // random traffic: R3 R5 R6 R7 R8 R9 R10 against the model
        for (int i = 0; i < 4000; i++) begin
            logic [7:0] a, d, cs, cmp;
            logic r, w;
            int k, op;
            k = $urandom_range(0, 9);
            case (k)
                0: a = 8'h04 | 8'($urandom_range(0, 1));
                1: a = 8'h06;
                2: a = 8'h0E;
                3: a = 8'h0F;
                6: a = 8'h21;
                7: a = 8'h22 | 8'($urandom_range(0, 1));
                8: a = 8'($urandom);
                default: a = 8'h10 + 8'($urandom_range(0, 15));
            endcase
            op = $urandom_range(0, 2);
            r  = (op == 1);
            w  = (op == 2);
            d  = 8'($urandom);
            cs = 8'($urandom) & 8'($urandom) & 8'($urandom);
            cmp = (i % 200 == 0) ? 8'($urandom) : ch_cmp_mode;
            cyc(a, r, w, d, cs, ($urandom_range(0, 7) == 0), ($urandom_range(0, 7) == 0),
                ($urandom_range(0, 7) == 0), cmp, "random R3 R5 R6 R7 R8 R9");
        end
        idle("final");
        finish_run();
    end
endmodule